// File: doc/BRIEF.md
# Double-Buffered Handshake Input Port

This block takes bytes from a peripheral over an 8-bit parallel pin bus. The peripheral places a byte on the pins and raises a strobe. The port captures the byte into a front latch. From there the byte moves into a back latch, and the CPU reads it from the back latch. A status flag tells the CPU that a byte is waiting. Because there are two stages, the peripheral can deliver one more byte while the CPU still has an unread one. Only when both stages are occupied must the peripheral stop.

A ready output tells the peripheral when the port can take another byte. A control bit selects how this output behaves. In interlocked mode it stays high for as long as the front latch is empty. In pulsed mode it gives a fixed-length pulse each time a byte leaves the front latch. The CPU uses a small synchronous register port to read the data, status and control registers, and to write the control register.

Top module: `hsin_port`

## Requirements
- R1: The strobe input passes through two synchroniser flip-flops and is then edge-detected. Each rising edge captures the pin byte into the front latch if that latch is empty. When both latches start empty, status bit 0 reads 1 at the fourth clock edge after the strobe rises.
- R2: When the front latch holds a byte and the back latch is empty, or is being read in the same cycle, the byte moves to the back latch on the next clock edge.
- R3: Reading address 0 returns the back-latch byte and empties the back latch. Status bit 0 then reads 0, unless a byte moves up from the front latch in that same cycle.
- R4: A strobe edge that arrives while both latches are full is ignored. Both stored bytes are kept and read out later unchanged.
- R5: The ready output is never high while the front latch holds a byte.
- R6: Address 2 is the control register, which is read/write. Bit 0 set to 0 selects interlocked mode, in which the ready output is high whenever the front latch is empty. Bit 0 set to 1 selects pulsed mode.
- R7: In pulsed mode, the ready output is high for exactly PULSE_LEN clock cycles (4 by default) after each byte leaves the front latch.
- R8: Address 1 is the status register. Bit 0 is high when a byte waits in the back latch. Bit 1 equals the current level of the ready output. All other bits read 0.
- R9: Reset empties both latches, clears the status, drives the ready output low and sets the control register to 0x01 (pulsed mode).
- R10: A strobe held high captures one byte only. A change of the pin data while the strobe stays high does not replace the captured byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| pin_data | input | DW | Byte on the peripheral pin bus |
| strb_in | input | 1 | Peripheral strobe; asynchronous, rising edge is active |
| hs_out | output | 1 | Ready handshake to the peripheral |
| rd_en | input | 1 | Register read strobe; a read of address 0 empties the back latch |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 reads zero |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected address |

## Verification
The first pattern sends one byte into an empty port. This checks the latency to the status flag and the width of the pulse, each counted edge by edge. The second pattern sends three bytes back to back without reads. This shows the difference between a byte that is buffered, a byte that is promoted during a read, and a byte that is dropped. The third pattern repeats the sequence in interlocked mode and checks that the ready output stays low while the front latch is occupied. The fourth pattern holds the strobe high while the pins change, which separates edge capture from level capture.

// File: rtl/hsin_pkg.sv
package hsin_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef enum logic {
    HS_INTERLOCK = 1'b0,
    HS_PULSED    = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/hsin_rst_sync.sv
module hsin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];
endmodule

// File: rtl/hsin_strobe_sync.sv
module hsin_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_in,
  output logic rise
);
  logic [2:0] sync_q;
  logic [2:0] sync_d;

  always_comb sync_d = {sync_q[1:0], strb_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= sync_d;
  end

  // sync_q[1] is the second synchroniser stage, sync_q[2] its delayed copy
  assign rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/hsin_latch_pair.sv
module hsin_latch_pair #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic [DW-1:0] pin_data,
  input  logic          pop,
  output logic          front_full,
  output logic [DW-1:0] front_q,
  output logic          back_full,
  output logic [DW-1:0] back_q,
  output logic          xfer
);
  logic          cap;
  logic          front_full_d, back_full_d;
  logic [DW-1:0] front_d, back_d;

  always_comb begin
    cap          = rise & ~front_full;
    xfer         = front_full & (~back_full | pop);
    front_d      = cap  ? pin_data : front_q;
    back_d       = xfer ? front_q  : back_q;
    front_full_d = cap  | (front_full & ~xfer);
    back_full_d  = xfer | (back_full & ~pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_full <= 1'b0;
      back_full  <= 1'b0;
    end else begin
      front_full <= front_full_d;
      back_full  <= back_full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_q <= '0;
      back_q  <= '0;
    end else begin
      if (cap)  front_q <= front_d;
      if (xfer) back_q  <= back_d;
    end
  end
endmodule

// File: rtl/hsin_hs_gen.sv
module hsin_hs_gen
  import hsin_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hs_mode_e mode,
  input  logic     front_full,
  input  logic     xfer,
  output logic     hs
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = xfer | (cnt_q != '0);
    if (xfer) cnt_d = CW'(PULSE_LEN);
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    if (mode == HS_INTERLOCK) hs = ~front_full;
    else                      hs = ~front_full & (cnt_q != '0);
  end
endmodule

// File: rtl/hsin_port.sv
module hsin_port
  import hsin_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_data,
  input  logic          strb_in,
  output logic          hs_out,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic          rst_n_s;
  logic          rise, pop, xfer;
  logic          front_full, back_full;
  logic [DW-1:0] front_q, back_q;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          ctrl_we;
  hs_mode_e      mode;

  hsin_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  hsin_strobe_sync u_sync (.clk(clk), .rst_n(rst_n_s), .strb_in(strb_in), .rise(rise));

  assign pop = rd_en & (addr == ADDR_DATA);

  hsin_latch_pair #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n_s), .rise(rise), .pin_data(pin_data), .pop(pop),
    .front_full(front_full), .front_q(front_q),
    .back_full(back_full), .back_q(back_q), .xfer(xfer)
  );

  always_comb begin
    ctrl_we = wr_en & (addr == ADDR_CTRL);
    ctrl_d  = wdata;
    mode    = hs_mode_e'(ctrl_q[0]);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     ctrl_q <= DW'(1);
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  hsin_hs_gen #(.PULSE_LEN(PULSE_LEN)) u_hs (
    .clk(clk), .rst_n(rst_n_s), .mode(mode),
    .front_full(front_full), .xfer(xfer), .hs(hs_out)
  );

  always_comb begin
    case (addr)
      ADDR_DATA: rdata = back_q;
      ADDR_STAT: rdata = {{(DW-2){1'b0}}, hs_out, back_full};
      ADDR_CTRL: rdata = ctrl_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/hsin_port_chk.sv
module hsin_port_chk #(
  parameter int DW        = 8,
  parameter int PULSE_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          front_full,
  input logic          back_full,
  input logic [DW-1:0] front_q,
  input logic          pop,
  input logic          hs,
  input logic          pulsed
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (hs && pulsed) begin
      if (run_q != RW'(PULSE_LEN + 1)) run_q <= run_q + 1'b1;
    end else run_q <= '0;
  end

  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_full |-> !hs);

  // R2
  promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_full && !back_full |=> back_full && !front_full);

  // R3
  pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && back_full && !front_full |=> !back_full);

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_full && back_full && !pop |=> front_full && $stable(front_q));

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(PULSE_LEN));
endmodule

bind hsin_port hsin_port_chk #(.DW(DW), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .front_full(front_full), .back_full(back_full),
  .front_q(front_q), .pop(pop), .hs(hs_out), .pulsed(ctrl_q[0])
);

// File: tb/test_hsin_port.sv
`timescale 1ns/1ps
module test_hsin_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_data;
  logic       strb_in;
  logic       hs_out;
  logic       rd_en, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hsin_port i_hsin_port (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .strb_in(strb_in),
    .hs_out(hs_out), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic read_reg(input logic [1:0] a, input bit consume, output logic [7:0] v);
    addr = a; rd_en = consume; #1; v = rdata;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    addr = 2'd2; wdata = v; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  // raise strobe with byte d, watch 12 edges; report first edge with status bit0 and ready-high count
  task automatic send_byte(input logic [7:0] d, output int first_h1s, output int hs_cnt);
    first_h1s = 0; hs_cnt = 0;
    pin_data = d; strb_in = 1'b1; addr = 2'd1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      if (i == 3) strb_in = 1'b0;
      #1;
      if (rdata[0] && first_h1s == 0) first_h1s = i;
      if (hs_out) hs_cnt++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst_n = 1'b0; strb_in = 1'b0; pin_data = 8'h00;
    rd_en = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check(hs_out == 1'b0, "R9 ready low", hs_out, 0);
    read_reg(2'd1, 1'b0, v);
    check(v == 8'h00, "R9 status clear", v, 0);
    read_reg(2'd2, 1'b0, v);
    check(v == 8'h01, "R9 control reset", v, 1);
  endtask

  task automatic t_single();
    int f, c; logic [7:0] v;
    send_byte(8'h5A, f, c);
    check(f == 4, "R1 status latency", f, 4);
    check(c == 4, "R7 pulse length", c, 4);
    read_reg(2'd1, 1'b0, v);
    check(v == 8'h01, "R8 status after pulse", v, 1);
    read_reg(2'd0, 1'b1, v);
    check(v == 8'h5A, "R3 data read", v, 8'h5A);
    read_reg(2'd1, 1'b0, v);
    check(v == 8'h00, "R3 flag cleared", v, 0);
  endtask

  task automatic t_burst();
    int f, c; logic [7:0] v;
    send_byte(8'hA1, f, c);
    send_byte(8'hB2, f, c);
    check(c == 0, "R5 no ready with front full", c, 0);
    send_byte(8'hC3, f, c);
    read_reg(2'd0, 1'b1, v);
    check(v == 8'hA1, "R2 first byte", v, 8'hA1);
    read_reg(2'd1, 1'b0, v);
    check(v[0] == 1'b1, "R2 promoted byte keeps flag", v[0], 1);
    read_reg(2'd0, 1'b1, v);
    check(v == 8'hB2, "R4 second byte kept, third dropped", v, 8'hB2);
    read_reg(2'd1, 1'b0, v);
    check(v[0] == 1'b0, "R4 no third byte", v[0], 0);
  endtask

  task automatic t_interlock();
    int f, c; logic [7:0] v;
    write_ctrl(8'h00);
    read_reg(2'd2, 1'b0, v);
    check(v == 8'h00, "R6 control readback", v, 0);
    check(hs_out == 1'b1, "R6 ready high when empty", hs_out, 1);
    read_reg(2'd1, 1'b0, v);
    check(v == 8'h02, "R8 status ready bit", v, 2);
    send_byte(8'h11, f, c);
    send_byte(8'h22, f, c);
    check(hs_out == 1'b0, "R5 ready low with front full", hs_out, 0);
    read_reg(2'd1, 1'b0, v);
    check(v == 8'h01, "R8 status both full", v, 1);
    read_reg(2'd0, 1'b1, v);
    check(v == 8'h11, "R3 interlocked data", v, 8'h11);
    check(hs_out == 1'b1, "R6 ready back after promote", hs_out, 1);
    read_reg(2'd0, 1'b1, v);
    check(v == 8'h22, "R2 interlocked second", v, 8'h22);
    write_ctrl(8'h01);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    pin_data = 8'h3C; strb_in = 1'b1;
    repeat (4) tick();
    pin_data = 8'hC3;
    repeat (16) tick();
    strb_in = 1'b0;
    repeat (6) tick();
    read_reg(2'd0, 1'b1, v);
    check(v == 8'h3C, "R10 single capture", v, 8'h3C);
    read_reg(2'd1, 1'b0, v);
    check(v[0] == 1'b0, "R10 no second capture", v[0], 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_burst();
    t_interlock();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule